// File: doc/BRIEF.md
# Tick-Driven Counter With Two Match Channels

This block is a bus-attached free-running counter for timekeeping and wake-up events. A `CNT_W`-bit up-counter (24 bits by default) advances on every clock edge at which the tick-enable input is high and counting is switched on. Two match registers each raise an event flag when the count passes through their value. Match channel 0 can also act as the wrap point, so the counter gives a periodic event with a programmable period.

Software reaches every register through a simple single-cycle bus with an address, a write strobe, write data and combinational read data. The event flags cannot be written directly. Software sets or clears them by writing ones to a set alias or a clear alias. One interrupt line is the OR of all flags that are enabled. A hold register lets software stage new control and match values and then apply them all on the same edge. A pending register shows which staged or just-applied updates have not yet settled. A debug-halt input pauses the counter unless the control register allows it to keep running.

Top module: `rtcc_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The byte offsets are: control 0x00, count 0x04, match 0 0x08, match 1 0x0C, flags 0x10, flag-set 0x14, flag-clear 0x18, irq-enable 0x1C, hold 0x20, pending 0x24. Unmapped offsets read zero.
- R2: The count advances by one on an edge only when control bit 0 (enable) is 1, `tick_en` is 1, and either `dbg_halt` is 0 or control bit 1 (debug-run) is 1. Otherwise it holds. Writes to the count offset have no effect.
- R3: When control bit 2 (match 0 is top) is 1 and the count equals match 0 on an advancing edge, the count becomes 0 and flag bit 0 (wrap) is set.
- R4: On an advancing edge at which the count is all ones, the count becomes 0 and flag bit 0 is set. This applies in either mode.
- R5: On an advancing edge at which the count equals match 0 or match 1, flag bit 1 or flag bit 2 is set, respectively.
- R6: Writing 1 to a bit of flag-set (0x14) sets that flag. Writing 1 to a bit of flag-clear (0x18) clears it. Zero bits and writes to the flags offset change nothing. A set beats a clear and a hardware event. A hardware event beats a clear on the same edge.
- R7: `irq` is high exactly when some flag bit and the irq-enable bit at the same position (bits 2:0) are both 1.
- R8: While hold bit 0 is 1, writes to control, match 0 and match 1 are staged and the live registers do not change. Writing hold bit 0 back to 0 applies every staged value on that one edge.
- R9: Pending bits 0, 1 and 2 (control, match 0, match 1) read 1 while an update to that register is staged under hold. They also read 1 for the two cycles after the register is written or its staged value is applied, and then return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count tick qualifier for the current cycle |
| dbg_halt | input | 1 | Debug halt request |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision of interest is a software flag-clear that lands on the same edge as a hardware match event for that flag. The bench counts cycles from a known wrap of the counter so that its flag-clear write to match-1 bit 2 commits exactly on the edge where the count passes the match-1 value. It then expects the flag to read 1, because the event wins. A second clear one write later must leave the flag at 0. The second coincidence is a hold release together with a control write that starts counting. The bench checks that all three registers change on the release edge and that the count starts advancing on the following edge.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int DATA_W = 32;
    localparam int NFLG   = 3;
    localparam int NSYNC  = 3;

    // register byte offsets (software decodes these)
    localparam int unsigned OFF_CTRL = 32'h00;
    localparam int unsigned OFF_CNT  = 32'h04;
    localparam int unsigned OFF_CMP0 = 32'h08;
    localparam int unsigned OFF_CMP1 = 32'h0C;
    localparam int unsigned OFF_FLG  = 32'h10;
    localparam int unsigned OFF_FSET = 32'h14;
    localparam int unsigned OFF_FCLR = 32'h18;
    localparam int unsigned OFF_IEN  = 32'h1C;
    localparam int unsigned OFF_HOLD = 32'h20;
    localparam int unsigned OFF_PEND = 32'h24;

    // flag bit positions
    localparam int FLG_WRAP = 0;
    localparam int FLG_M0   = 1;
    localparam int FLG_M1   = 2;

    // pending bit positions
    localparam int SY_CTRL = 0;
    localparam int SY_CMP0 = 1;
    localparam int SY_CMP1 = 2;

    typedef struct packed {
        logic top0;    // bit 2
        logic dbgrun;  // bit 1
        logic en;      // bit 0
    } ctrl_t;

endpackage

// File: rtl/rtcc_regs.sv
module rtcc_regs
    import rtcc_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int BUSY_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_cmp0,
    input  logic               wr_cmp1,
    input  logic               wr_ien,
    input  logic               wr_hold,
    input  logic [CNT_W-1:0]   wdata,
    output ctrl_t              ctrl,
    output logic [CNT_W-1:0]   cmp0,
    output logic [CNT_W-1:0]   cmp1,
    output logic [NFLG-1:0]    ien,
    output logic               hold,
    output logic [NSYNC-1:0]   busy
);
    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] BUSY_LD = BW'(BUSY_CYC);

    typedef struct packed {
        ctrl_t                       ctrl;
        ctrl_t                       ctrl_sh;
        logic [CNT_W-1:0]            cmp0;
        logic [CNT_W-1:0]            cmp1;
        logic [CNT_W-1:0]            cmp0_sh;
        logic [CNT_W-1:0]            cmp1_sh;
        logic [NSYNC-1:0]            pend;
        logic [NSYNC-1:0][BW-1:0]    bcnt;
        logic [NFLG-1:0]             ien;
        logic                        hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < NSYNC; j++) begin
            if (st_q.bcnt[j] != '0) begin
                st_d.bcnt[j] = st_q.bcnt[j] - 1'b1;
            end
        end

        if (wr_ien) begin
            st_d.ien = wdata[NFLG-1:0];
        end

        if (wr_ctrl) begin
            if (st_q.hold) begin
                st_d.ctrl_sh       = ctrl_t'(wdata[2:0]);
                st_d.pend[SY_CTRL] = 1'b1;
            end else begin
                st_d.ctrl          = ctrl_t'(wdata[2:0]);
                st_d.bcnt[SY_CTRL] = BUSY_LD;
            end
        end

        if (wr_cmp0) begin
            if (st_q.hold) begin
                st_d.cmp0_sh       = wdata;
                st_d.pend[SY_CMP0] = 1'b1;
            end else begin
                st_d.cmp0          = wdata;
                st_d.bcnt[SY_CMP0] = BUSY_LD;
            end
        end

        if (wr_cmp1) begin
            if (st_q.hold) begin
                st_d.cmp1_sh       = wdata;
                st_d.pend[SY_CMP1] = 1'b1;
            end else begin
                st_d.cmp1          = wdata;
                st_d.bcnt[SY_CMP1] = BUSY_LD;
            end
        end

        if (wr_hold) begin
            st_d.hold = wdata[0];
            if (st_q.hold && !wdata[0]) begin
                if (st_q.pend[SY_CTRL]) begin
                    st_d.ctrl          = st_q.ctrl_sh;
                    st_d.bcnt[SY_CTRL] = BUSY_LD;
                end
                if (st_q.pend[SY_CMP0]) begin
                    st_d.cmp0          = st_q.cmp0_sh;
                    st_d.bcnt[SY_CMP0] = BUSY_LD;
                end
                if (st_q.pend[SY_CMP1]) begin
                    st_d.cmp1          = st_q.cmp1_sh;
                    st_d.bcnt[SY_CMP1] = BUSY_LD;
                end
                st_d.pend = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar j = 0; j < NSYNC; j++) begin : g_busy
        assign busy[j] = st_q.pend[j] | (st_q.bcnt[j] != '0);
    end

    assign ctrl = st_q.ctrl;
    assign cmp0 = st_q.cmp0;
    assign cmp1 = st_q.cmp1;
    assign ien  = st_q.ien;
    assign hold = st_q.hold;

endmodule

// File: rtl/rtcc_count.sv
module rtcc_count
    import rtcc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [CNT_W-1:0]   cmp0,
    input  logic [CNT_W-1:0]   cmp1,
    input  logic               tick_en,
    input  logic               dbg_halt,
    output logic [CNT_W-1:0]   cnt,
    output logic [NFLG-1:0]    evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic adv;
    logic at_top;

    always_comb begin
        adv    = ctrl.en && tick_en && (!dbg_halt || ctrl.dbgrun);
        at_top = (ctrl.top0 && (st_q.cnt == cmp0)) || (st_q.cnt == CNT_MAX);

        evt           = '0;
        evt[FLG_WRAP] = adv && at_top;
        evt[FLG_M0]   = adv && (st_q.cnt == cmp0);
        evt[FLG_M1]   = adv && (st_q.cnt == cmp1);

        st_d = st_q;
        if (adv) begin
            st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rtcc_flags.sv
module rtcc_flags
    import rtcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NFLG-1:0]    set_mask,
    input  logic [NFLG-1:0]    clr_mask,
    input  logic [NFLG-1:0]    evt,
    input  logic [NFLG-1:0]    ien,
    output logic [NFLG-1:0]    flags,
    output logic               irq
);
    typedef struct packed {
        logic [NFLG-1:0] flg;
    } st_t;

    st_t st_d, st_q;

    // priority: software set > hardware event > software clear
    always_comb begin
        st_d     = st_q;
        st_d.flg = (st_q.flg & ~clr_mask) | evt | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flg;
    assign irq   = |(st_q.flg & ien);

endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int ADDR_W   = 8,
    parameter int BUSY_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               dbg_halt,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);
    ctrl_t              ctrl_w;
    logic [CNT_W-1:0]   cmp0_w, cmp1_w, cnt_w;
    logic [NFLG-1:0]    ien_w, flags_w, evt_w, set_w, clr_w;
    logic [NSYNC-1:0]   busy_w;
    logic               hold_w;
    logic               wr_ctrl, wr_cmp0, wr_cmp1, wr_ien, wr_hold;
    logic               unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
        wr_cmp0 = bus_we && (bus_addr == ADDR_W'(OFF_CMP0));
        wr_cmp1 = bus_we && (bus_addr == ADDR_W'(OFF_CMP1));
        wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
        wr_hold = bus_we && (bus_addr == ADDR_W'(OFF_HOLD));
        set_w   = (bus_we && (bus_addr == ADDR_W'(OFF_FSET))) ? bus_wdata[NFLG-1:0] : '0;
        clr_w   = (bus_we && (bus_addr == ADDR_W'(OFF_FCLR))) ? bus_wdata[NFLG-1:0] : '0;
    end

    rtcc_regs #(.CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_cmp0 (wr_cmp0),
        .wr_cmp1 (wr_cmp1),
        .wr_ien  (wr_ien),
        .wr_hold (wr_hold),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .ctrl    (ctrl_w),
        .cmp0    (cmp0_w),
        .cmp1    (cmp1_w),
        .ien     (ien_w),
        .hold    (hold_w),
        .busy    (busy_w)
    );

    rtcc_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_w),
        .cmp0     (cmp0_w),
        .cmp1     (cmp1_w),
        .tick_en  (tick_en),
        .dbg_halt (dbg_halt),
        .cnt      (cnt_w),
        .evt      (evt_w)
    );

    rtcc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_w),
        .clr_mask (clr_w),
        .evt      (evt_w),
        .ien      (ien_w),
        .flags    (flags_w),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CTRL): bus_rdata = DATA_W'(ctrl_w);
            ADDR_W'(OFF_CNT):  bus_rdata = DATA_W'(cnt_w);
            ADDR_W'(OFF_CMP0): bus_rdata = DATA_W'(cmp0_w);
            ADDR_W'(OFF_CMP1): bus_rdata = DATA_W'(cmp1_w);
            ADDR_W'(OFF_FLG):  bus_rdata = DATA_W'(flags_w);
            ADDR_W'(OFF_IEN):  bus_rdata = DATA_W'(ien_w);
            ADDR_W'(OFF_HOLD): bus_rdata = DATA_W'(hold_w);
            ADDR_W'(OFF_PEND): bus_rdata = DATA_W'(busy_w);
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk
    import rtcc_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               dbg_halt,
    input logic               we,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input ctrl_t              ctrl,
    input logic               hold,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   cmp0,
    input logic [CNT_W-1:0]   cmp1,
    input logic [NFLG-1:0]    flags,
    input logic [NFLG-1:0]    ien,
    input logic [NSYNC-1:0]   busy,
    input logic               irq
);
    logic adv;
    assign adv = ctrl.en && tick_en && (!dbg_halt || ctrl.dbgrun);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));

    // R3
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ctrl.top0 && cnt == cmp0) |=> (cnt == '0 && flags[FLG_WRAP]));

    // R4
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == '1) |=> (cnt == '0 && flags[FLG_WRAP]));

    // R5
    m1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == cmp1) |=> flags[FLG_M1]);

    // R6
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_FSET)) |=> ((flags & $past(wdata[NFLG-1:0])) == $past(wdata[NFLG-1:0])));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R8
    held_cmp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && we && addr == ADDR_W'(OFF_CMP0)) |=> $stable(cmp0));

    // R9
    ctrl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_CTRL)) |=> busy[SY_CTRL]);

endmodule

bind rtcc_top rtcc_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .dbg_halt (dbg_halt),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ctrl     (ctrl_w),
    .hold     (hold_w),
    .cnt      (cnt_w),
    .cmp0     (cmp0_w),
    .cmp1     (cmp1_w),
    .flags    (flags_w),
    .ien      (ien_w),
    .busy     (busy_w),
    .irq      (irq)
);

// File: tb/rtcc_top_tb.sv
`timescale 1ns/1ps
module rtcc_top_tb;
    localparam int CW = 8;   // narrow counter so the full wrap is reachable

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        dbg_halt = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtcc_top #(.CNT_W(CW), .ADDR_W(8), .BUSY_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {offset, data, expected flags, expected irq}
    localparam logic [43:0] VEC [11] = '{
        {8'h14, 32'h7, 3'h7, 1'b0},
        {8'h1C, 32'h2, 3'h7, 1'b1},
        {8'h18, 32'h2, 3'h5, 1'b0},
        {8'h1C, 32'h5, 3'h5, 1'b1},
        {8'h18, 32'h5, 3'h0, 1'b0},
        {8'h14, 32'h0, 3'h0, 1'b0},
        {8'h14, 32'h4, 3'h4, 1'b1},
        {8'h18, 32'h0, 3'h4, 1'b1},
        {8'h1C, 32'h0, 3'h4, 1'b0},
        {8'h18, 32'h7, 3'h0, 1'b0},
        {8'h10, 32'h7, 3'h0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        logic [31:0] c;

        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // R1: reset values and offsets
        for (int a = 0; a <= 'h28; a += 4) begin
            rd(8'(a), d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R6 / R7: vector table, counter idle
        for (int i = 0; i < 11; i++) begin
            wr(VEC[i][43:36], VEC[i][35:4]);
            rd(8'h10, d);
            chk("R6 flag vector", d, {29'h0, VEC[i][3:1]});
            chk("R7 irq vector", {31'h0, irq}, {31'h0, VEC[i][0]});
        end

        // R3 / R5 / R9: top mode, match0=10, match1=5
        wr(8'h08, 32'd10);
        wr(8'h0C, 32'd5);
        wr(8'h18, 32'h7);
        wr(8'h00, 32'h5);
        rd(8'h04, d); chk("R2 count starts at 0", d, 32'd0);
        rd(8'h24, d); chk("R9 busy after ctrl write", d, 32'h1);
        waitn(1);
        rd(8'h24, d); chk("R9 busy second cycle", d, 32'h1);
        waitn(1);
        rd(8'h24, d); chk("R9 busy cleared", d, 32'h0);
        waitn(3);
        rd(8'h04, d); chk("R2 count at 5", d, 32'd5);
        rd(8'h10, d); chk("R5 match1 not yet", d & 32'h4, 32'h0);
        waitn(1);
        rd(8'h10, d); chk("R5 match1 flag", d & 32'h4, 32'h4);
        waitn(4);
        rd(8'h04, d); chk("R3 count at top", d, 32'd10);
        rd(8'h10, d); chk("R3 no wrap yet", d & 32'h3, 32'h0);
        waitn(1);
        rd(8'h04, d); chk("R3 wrapped to 0", d, 32'd0);
        rd(8'h10, d); chk("R3 wrap and match0 flags", d & 32'h3, 32'h3);

        // stop counting (one more advance on this edge)
        wr(8'h00, 32'h0);
        rd(8'h04, v);
        chk("R2 stopped value", v, 32'd1);
        wr(8'h04, 32'hAB);
        rd(8'h04, d); chk("R2 count write ignored", d, v);

        // R8 / R9: hold and release
        wr(8'h20, 32'h1);
        wr(8'h08, 32'h20);
        wr(8'h0C, 32'h30);
        wr(8'h00, 32'h1);
        rd(8'h08, d); chk("R8 match0 held", d, 32'd10);
        rd(8'h00, d); chk("R8 ctrl held", d, 32'h0);
        rd(8'h24, d); chk("R9 pending while held", d, 32'h7);
        waitn(4);
        rd(8'h24, d); chk("R9 pending persists", d, 32'h7);
        rd(8'h04, d); chk("R8 count idle while held", d, v);
        wr(8'h20, 32'h0);
        rd(8'h00, d); chk("R8 ctrl applied", d, 32'h1);
        rd(8'h08, d); chk("R8 match0 applied", d, 32'h20);
        rd(8'h0C, d); chk("R8 match1 applied", d, 32'h30);
        rd(8'h04, d); chk("R8 count not yet moving", d, v);
        rd(8'h24, d); chk("R9 busy after release", d, 32'h7);
        waitn(1);
        rd(8'h24, d); chk("R9 busy release second", d, 32'h7);
        rd(8'h04, d); chk("R8 count moving", d, v + 1);
        waitn(1);
        rd(8'h24, d); chk("R9 busy release cleared", d, 32'h0);
        rd(8'h04, d); chk("R2 count advancing", d, v + 2);

        // R2: debug halt and tick gating
        dbg_halt = 1'b1;
        waitn(3);
        rd(8'h04, d); chk("R2 halted by debug", d, v + 2);
        dbg_halt = 1'b0;
        tick_en  = 1'b0;
        waitn(2);
        rd(8'h04, d); chk("R2 no tick no count", d, v + 2);
        tick_en  = 1'b1;
        dbg_halt = 1'b1;
        wr(8'h00, 32'h3);
        rd(8'h04, d); chk("R2 halted through write", d, v + 2);
        waitn(2);
        rd(8'h04, d); chk("R2 debug-run counts", d, v + 4);
        dbg_halt = 1'b0;

        // R4: full-range wrap
        wr(8'h18, 32'h7);
        rd(8'h04, c);
        waitn(255 - int'(c));
        rd(8'h04, d); chk("R4 count at all ones", d, 32'hFF);
        rd(8'h10, d); chk("R4 no wrap yet", d & 32'h1, 32'h0);
        waitn(1);
        rd(8'h04, d); chk("R4 wrapped to 0", d, 32'h0);
        rd(8'h10, d); chk("R4 wrap flag", d & 32'h1, 32'h1);

        // R6: clear colliding with match1 event (event wins)
        wr(8'h18, 32'h7);
        waitn(47);
        rd(8'h04, d); chk("R5 count at match1", d, 32'h30);
        rd(8'h10, d); chk("R5 match1 clear before", d & 32'h4, 32'h0);
        wr(8'h18, 32'h4);
        rd(8'h10, d); chk("R6 event beats clear", d & 32'h4, 32'h4);
        wr(8'h18, 32'h4);
        rd(8'h10, d); chk("R6 later clear works", d & 32'h4, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule